// File: doc/BRIEF.md
# Stochastic Carry-Limited Adder Emulator

This block behaves like an N-bit adder whose timing is too tight for its supply. It does not flip bits at random. For every operand pair it works out how long a carry must ripple in the exact sum. It then draws a pseudo-random carry-chain limit from a programmable table that is conditioned on that length. The result it returns is the sum with every carry that would need a longer chain than the limit forced to zero. A model of this kind stands in for an adder under aggressive voltage scaling in an error-tolerant datapath, without slowing the rest of the design down to transistor-level detail.

Operands enter on a valid/ready pair. The sum leaves N+1 bits wide on a valid/ready pair. A write port fills the per-column cumulative thresholds. A second write port loads the 16-bit pseudo-random generator, so that a test can predict its sequence. After reset every threshold is zero, and the block then acts as an exact adder.

Top module: `stoch_carry_adder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every threshold is 0, so every sum is exact.
- R2: The theoretical chain length `L` is measured over every result bit `i` from 1 to N, with bit N being the carry-out. Let `j` be the nearest bit below `i` where both operand bits are 1, with every bit between them having operand bits that differ. Bit `i` then has chain length `i-j`, and `L` is the largest such length. When the drawn limit is at least `L`, the result equals `a+b`.
- R3: An operand pair with `L = 0` always yields the exact sum, whatever the table holds.
- R4: The limit drawn for column `L` and sample `s` is the smallest `k <= L` whose stored threshold for (column `L`, row `k`) is greater than `s`. If no row qualifies, the limit is `L`. With a limit of `C`, the carry into bit `i` is 1 only if it is produced within bits `i-C..i-1`. Result bit `i < N` is `a[i]^b[i]^carry`, and bit N is the limited carry-out.
- R5: A table write whose row is greater than its column changes no stored threshold.
- R6: The generator is a 16-bit Galois shift register that shifts right and XORs in 0xB400 when the bit shifted out is 1. It advances once per accepted operand pair, and that pair uses the state held before the advance. A seed load takes priority over the advance in the same cycle: the pair accepted in that cycle still uses the old state. A seed of 0 is loaded as 1.
- R7: A pair accepted at one clock edge appears on `out_sum` with `out_valid` after the second edge that follows. One pair can be accepted per cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_sum` holds its value and `in_ready` is 0.
- R9: The result never exceeds the exact sum `a+b`.
- R10: A table write at the same edge that performs a pair's threshold lookup is not seen by that lookup. The lookup takes place one edge after the pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pair accepted when high with in_valid |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | N+1 | Carry-limited sum, carry-out in the top bit |
| tbl_we | input | 1 | Threshold write strobe |
| tbl_col | input | $clog2(N+1) | Column (theoretical chain length) |
| tbl_row | input | $clog2(N+1) | Row (candidate limit) |
| tbl_data | input | 16 | Cumulative threshold value |
| seed_we | input | 1 | Generator seed load strobe |
| seed_data | input | 16 | Seed value |

## Verification
Two pairs of functions can fall in the same cycle. The first is a threshold write and the lookup for a pair already in flight. The bench writes column 8 at the edge after the accept of 0xFF+0x01 and expects the untouched sum 0x100. It then writes at the very edge of an accept and expects the new contents to be used. The second is a seed load and an accept. The bench issues both together and judges from the results of that pair and of the next pair that the old state was used before the new seed took over. Everything else is compared with an arithmetic model in the bench: an exhaustive 8-bit sweep against `a+b`, and a random sweep with a graded table and random back-pressure.

// File: rtl/stoch_carry_adder.sv
module stoch_carry_adder #(
  parameter int N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N-1:0]             in_a,
  input  logic [N-1:0]             in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [N:0]               out_sum,
  input  logic                     tbl_we,
  input  logic [$clog2(N+1)-1:0]   tbl_col,
  input  logic [$clog2(N+1)-1:0]   tbl_row,
  input  logic [15:0]              tbl_data,
  input  logic                     seed_we,
  input  logic [15:0]              seed_data
);
  localparam int CW = $clog2(N+1);
  localparam int TE = (N+1)*(N+2)/2;
  localparam logic [15:0] TAPS = 16'hB400;

  function automatic int tidx(input int l, input int k);
    return l*(l+1)/2 + k;
  endfunction

  function automatic logic [CW-1:0] chain_len(input logic [N-1:0] a, input logic [N-1:0] b);
    int best, d;
    logic run;
    best = 0;
    for (int i = 1; i <= N; i++) begin
      d = 0;
      run = 1'b1;
      for (int j = N-1; j >= 0; j--) begin
        if (j < i && run) begin
          if (a[j] & b[j]) begin
            d = i - j;
            run = 1'b0;
          end else if (!(a[j] ^ b[j])) begin
            run = 1'b0;
          end
        end
      end
      if (d > best) best = d;
    end
    return CW'(best);
  endfunction

  function automatic logic [N:0] lim_sum(input logic [N-1:0] a, input logic [N-1:0] b,
                                         input logic [CW-1:0] c);
    logic [N:0] px, r;
    logic cy, run;
    px = {1'b0, a ^ b};
    r = '0;
    for (int i = 0; i <= N; i++) begin
      cy = 1'b0;
      run = 1'b1;
      for (int j = N-1; j >= 0; j--) begin
        if (j < i && run && (i - j) <= int'(c)) begin
          if (a[j] & b[j]) begin
            cy = 1'b1;
            run = 1'b0;
          end else if (!(a[j] ^ b[j])) begin
            run = 1'b0;
          end
        end
      end
      r[i] = px[i] ^ cy;
    end
    return r;
  endfunction

  logic [15:0]   thr [TE];
  logic [15:0]   lfsr;
  logic          v1, v2, vo;
  logic [N-1:0]  a1, b1, a2, b2;
  logic [CW-1:0] c1, c2, lim2, lim_nx;
  logic [15:0]   r1;
  logic          adv;

  assign adv       = !vo || out_ready;
  assign in_ready  = adv;
  assign out_valid = vo;

  always_comb begin
    lim_nx = c1;
    for (int k = N; k >= 0; k--)
      if (k <= int'(c1) && thr[tidx(int'(c1), k)] > r1) lim_nx = CW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TE; i++) thr[i] <= '0;
    end else if (tbl_we && tbl_row <= tbl_col && int'(tbl_col) <= N) begin
      thr[tidx(int'(tbl_col), int'(tbl_row))] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'h0001;
    end else if (seed_we) begin
      lfsr <= (seed_data == '0) ? 16'h0001 : seed_data;
    end else if (in_valid && adv) begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; vo <= 1'b0;
      a1 <= '0; b1 <= '0; c1 <= '0; r1 <= '0;
      a2 <= '0; b2 <= '0; c2 <= '0; lim2 <= '0;
      out_sum <= '0;
    end else if (adv) begin
      v1 <= in_valid;
      if (in_valid) begin
        a1 <= in_a;
        b1 <= in_b;
        c1 <= chain_len(in_a, in_b);
        r1 <= lfsr;
      end
      v2 <= v1;
      if (v1) begin
        a2 <= a1; b2 <= b1; c2 <= c1; lim2 <= lim_nx;
      end
      vo <= v2;
      if (v2) out_sum <= lim_sum(a2, b2, lim2);
    end
  end

  a_r4_limit_within_chain: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> lim2 <= c2);

  a_r2_full_limit_exact: assert property (@(posedge clk) disable iff (!rst_n)
    adv && v2 && lim2 >= c2 |=> out_sum == $past({1'b0, a2} + {1'b0, b2}));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    adv && v2 |=> out_sum <= $past({1'b0, a2} + {1'b0, b2}));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    vo && !out_ready |=> vo && $stable(out_sum));

  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);
endmodule

// File: tb/tb_stoch_carry_adder.sv
module tb_stoch_carry_adder;
  localparam int N = 8;
  localparam int CW = $clog2(N+1);
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [N-1:0] in_a = '0, in_b = '0;
  logic [N:0] out_sum;
  logic tbl_we = 1'b0, seed_we = 1'b0;
  logic [CW-1:0] tbl_col = '0, tbl_row = '0;
  logic [15:0] tbl_data = '0, seed_data = '0;

  stoch_carry_adder #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .tbl_we(tbl_we), .tbl_col(tbl_col), .tbl_row(tbl_row),
    .tbl_data(tbl_data), .seed_we(seed_we), .seed_data(seed_data));

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0;
  logic [15:0] mthr [0:N][0:N];
  logic [15:0] mst = 16'h0001;
  logic [N:0] exp_q [$];
  string tag_q [$];
  string cur_tag = "R2";
  logic [N:0] last_out = '0;

  function automatic int m_chain(input logic [N-1:0] a, input logic [N-1:0] b);
    int best = 0;
    for (int i = 1; i <= N; i++) begin
      for (int j = i-1; j >= 0; j--) begin
        if (a[j] && b[j]) begin
          if (i - j > best) best = i - j;
          break;
        end
        if (a[j] == b[j]) break;
      end
    end
    return best;
  endfunction

  function automatic logic [N:0] m_sum(input logic [N-1:0] a, input logic [N-1:0] b, input int c);
    logic [N:0] r = '0;
    logic cy;
    for (int i = 0; i <= N; i++) begin
      cy = 1'b0;
      for (int j = i-1; j >= 0 && i - j <= c; j--) begin
        if (a[j] && b[j]) begin cy = 1'b1; break; end
        if (a[j] == b[j]) break;
      end
      r[i] = (i < N) ? (a[i] ^ b[i] ^ cy) : cy;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [N-1:0] a, input logic [N-1:0] b,
                      input logic ordy, input logic twe, input int col, input int row,
                      input logic [15:0] td, input logic swe, input logic [15:0] sd);
    logic [N:0] e;
    int l, sel;
    string t;
    @(negedge clk);
    in_valid = iv; in_a = a; in_b = b; out_ready = ordy;
    tbl_we = twe; tbl_col = CW'(col); tbl_row = CW'(row); tbl_data = td;
    seed_we = swe; seed_data = sd;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected output", out_sum, ~out_sum);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_out = out_sum;
        chk(t, out_sum, e);
      end
    end
    if (twe && row <= col) mthr[col][row] = td;
    if (iv && in_ready) begin
      l = m_chain(a, b);
      sel = l;
      for (int k = l; k >= 0; k--) if (mthr[l][k] > mst) sel = k;
      exp_q.push_back(m_sum(a, b, sel));
      tag_q.push_back(cur_tag);
    end
    if (swe) mst = (sd == 16'h0) ? 16'h0001 : sd;
    else if (iv && in_ready) mst = {1'b0, mst[15:1]} ^ (mst[0] ? 16'hB400 : 16'h0);
  endtask

  task automatic idle(); step(0, '0, '0, 1, 0, 0, 0, '0, 0, '0); endtask
  task automatic put(input logic [N-1:0] a, input logic [N-1:0] b);
    step(1, a, b, 1, 0, 0, 0, '0, 0, '0);
  endtask
  task automatic wr(input int col, input int row, input logic [15:0] d);
    step(0, '0, '0, 1, 1, col, row, d, 0, '0);
  endtask
  task automatic seed(input logic [15:0] s); step(0, '0, '0, 1, 0, 0, 0, '0, 1, s); endtask
  task automatic drain();
    while (exp_q.size() != 0) idle();
    idle();
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int l = 0; l <= N; l++) for (int k = 0; k <= N; k++) mthr[l][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 out_valid after reset", {{N{1'b0}}, out_valid}, '0);
    chk("R1 in_ready after reset", {{N{1'b0}}, in_ready}, 1);

    cur_tag = "R1";
    put(8'hFF, 8'h01); drain();
    chk("R1 exact with reset table", last_out, 9'h100);

    cur_tag = "R3";
    wr(0, 0, 16'hFFFF);
    put(8'h55, 8'hAA); drain();
    chk("R3 zero chain exact", last_out, 9'h0FF);

    cur_tag = "R5";
    wr(3, 5, 16'hFFFF);
    put(8'h07, 8'h01); drain();
    chk("R5 ignored write col3", last_out, 9'h008);
    put(8'h0F, 8'h01); drain();
    chk("R5 ignored write col4", last_out, 9'h010);

    cur_tag = "R7";
    put(8'h01, 8'h02);
    idle(); chk("R7 not valid after 1 edge", {{N{1'b0}}, out_valid}, 0);
    idle(); chk("R7 not valid after 2 edges", {{N{1'b0}}, out_valid}, 0);
    idle(); chk("R7 valid after 3rd step", {{N{1'b0}}, out_valid}, 1);
    drain();
    chk("R7 latency value", last_out, 9'h003);

    cur_tag = "R4";
    seed(16'h1234);
    wr(8, 0, 16'hFFFF);
    put(8'hFF, 8'h01); drain();
    chk("R4 limit zero drops all carries", last_out, 9'h0FE);
    chk("R9 limited not above exact", (last_out <= 9'h100) ? 9'h1 : 9'h0, 9'h1);

    cur_tag = "R10";
    wr(8, 0, 16'h0000);
    seed(16'h1234);
    put(8'hFF, 8'h01);
    wr(8, 0, 16'hFFFF);
    drain();
    chk("R10 write at lookup edge unseen", last_out, 9'h100);
    step(1, 8'hFF, 8'h01, 1, 1, 8, 0, 16'h0000, 0, '0);
    drain();
    chk("R10 write at accept edge seen", last_out, 9'h100);

    cur_tag = "R6";
    seed(16'h0000);
    wr(8, 0, 16'h0001);
    put(8'hFF, 8'h01); drain();
    chk("R6 zero seed becomes one", last_out, 9'h100);
    wr(8, 0, 16'h1235);
    step(1, 8'hFF, 8'h01, 1, 0, 0, 0, '0, 1, 16'h1234);
    drain();
    chk("R6 accept with seed load uses old state", last_out, 9'h100);
    put(8'hFF, 8'h01); drain();
    chk("R6 next accept uses new seed", last_out, 9'h0FE);

    cur_tag = "R8";
    for (int i = 0; i < 4; i++) step(1, 8'(i + 1), 8'h0F, 0, 0, 0, 0, '0, 0, '0);
    chk("R8 in_ready low on stall", {{N{1'b0}}, in_ready}, 0);
    last_out = out_sum;
    step(1, 8'h33, 8'h0F, 0, 0, 0, 0, '0, 0, '0);
    chk("R8 out_sum held", out_sum, last_out);
    chk("R8 out_valid held", {{N{1'b0}}, out_valid}, 1);
    drain();

    cur_tag = "R2";
    for (int l = 0; l <= N; l++) for (int k = 0; k <= l; k++) wr(l, k, 16'h0000);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        put(8'(a), 8'(b));
        if (exp_q.size() != 0 && exp_q[exp_q.size()-1] !== 9'(a + b))
          chk("R2 model vs arithmetic", exp_q[exp_q.size()-1], 9'(a + b));
      end
    drain();

    cur_tag = "R4";
    for (int l = 0; l <= N; l++)
      for (int k = 0; k <= l; k++) wr(l, k, 16'(((k + 1) * 65536) / (l + 2)));
    seed(16'hACE1);
    for (int i = 0; i < 20000; i++) begin
      if (i % 1000 == 500)
        step(1, 8'($urandom), 8'($urandom), 1'($urandom), 0, 0, 0, '0, 1, 16'($urandom));
      else
        step(1, 8'($urandom), 8'($urandom), ($urandom % 4) != 0, 0, 0, 0, '0, 0, '0);
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule